// File: doc/BRIEF.md
# Saturating Up/Down Wiper Position Controller

This block is the digital control core of a 128-step digital potentiometer. Three asynchronous control lines drive it: an active-low select (`sel_n`), a step strobe (`step`, idle high, acting on its falling edge) and a direction line (`dir_up`). While the block is selected, each falling edge of `step` moves a 7-bit wiper position by one place, up or down. The position stops at either end instead of wrapping. The position is also presented as a one-hot tap-select bus, so exactly one tap switch is closed at any time.

When the select line is released while `step` is high, the block copies the current position into a nonvolatile register model. That model is a plain register with a busy timer of `STORE_CYCLES` clocks. When the timer ends, the block enters standby, where it stays until it is selected again. Releasing the select line while `step` is low ends the session and writes nothing.

A warm reset (`rst_n`) restores the position from the stored value, and `ready` rises after `PWRUP_CYCLES` clocks. A cold power-on (`pwr_on_n`) also sets the stored value to `INIT_POS`. The controller is a state machine with these states:
- ST_POWERUP: recall and power-up delay.
- ST_IDLE: deselected.
- ST_ACTIVE: selected, steps are accepted.
- ST_STORE: write in progress.
- ST_STANDBY: after a write.

It takes these transitions:
- ST_POWERUP goes to ST_IDLE when the delay expires.
- ST_IDLE and ST_STANDBY go to ST_ACTIVE when the synchronized select is low.
- ST_ACTIVE goes to ST_STORE when the select releases with `step` high.
- ST_ACTIVE goes to ST_IDLE when the select releases with `step` low.
- ST_STORE goes to ST_STANDBY when the write timer finishes.

Top module: `wiper_ctrl`

## Requirements
- R1: `wiper_pos` is a 7-bit value from 0 to 127. `tap_sel` has exactly one bit set, and that bit's index equals `wiper_pos`.
- R2: While the block is selected (`sel_n` = 0), each falling edge of `step` changes `wiper_pos` by exactly one, within 6 clocks of the edge. `dir_up` = 1 counts up and `dir_up` = 0 counts down.
- R3: A step up at 127 leaves the position at 127, and a step down at 0 leaves it at 0. The position never wraps.
- R4: While `sel_n` is high, falling edges of `step` leave `wiper_pos` unchanged.
- R5: A rising edge of `sel_n` while `step` is high stores the position. `busy` is then high for `STORE_CYCLES` clocks, after which `standby` is high until `sel_n` goes low.
- R6: A rising edge of `sel_n` while `step` is low stores nothing. `busy` stays low, and a later warm reset recalls the previously stored value.
- R7: While `busy` is high, step edges and reselection leave `wiper_pos` unchanged.
- R8: After `rst_n` is released, `wiper_pos` equals the stored value. `ready` is low for `PWRUP_CYCLES` clocks and then high, and step edges before `ready` have no effect.
- R9: After a cold power-on (`pwr_on_n` low), the stored value and `wiper_pos` both equal `INIT_POS` (default 64).
- R10: `busy` and `standby` are never high together, and both are low while `ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| pwr_on_n | input | 1 | Cold power-on reset, active low; also clears the stored value to INIT_POS |
| rst_n | input | 1 | Warm reset, active low; triggers recall from storage |
| sel_n | input | 1 | Active-low select, asynchronous |
| step | input | 1 | Step strobe, idle high, acts on its falling edge, asynchronous |
| dir_up | input | 1 | Direction: 1 counts up, 0 counts down, asynchronous |
| wiper_pos | output | 7 | Current wiper position |
| tap_sel | output | 128 | One-hot tap select |
| busy | output | 1 | Nonvolatile write in progress |
| ready | output | 1 | Power-up delay complete |
| standby | output | 1 | Low-power standby after a write |

## Verification
The assertions assume that `sel_n`, `step` and `dir_up` stay stable for several clocks around each change. The stored value must also survive a warm reset, so only `pwr_on_n` clears it. The stimulus holds each level of `step` for four clocks and changes `dir_up` only while `step` is high. It drops `sel_n` before the first step edge, and it waits for the synchronizers to settle before every select change or check.

// File: rtl/wiper_pkg.sv
`timescale 1ns/1ps
package wiper_pkg;
    typedef enum logic [2:0] {
        ST_POWERUP = 3'd0,
        ST_IDLE    = 3'd1,
        ST_ACTIVE  = 3'd2,
        ST_STORE   = 3'd3,
        ST_STANDBY = 3'd4
    } wstate_e;
endpackage

// File: rtl/wiper_sync.sv
`timescale 1ns/1ps
// Two-flop synchronizer bank with a per-bit reset value.
module wiper_sync #(
    parameter int          N       = 3,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    logic [N-1:0] meta;

    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta[i] <= RST_VAL[i];
                q[i]    <= RST_VAL[i];
            end else begin
                meta[i] <= d[i];
                q[i]    <= meta[i];
            end
        end
    end
endmodule

// File: rtl/wiper_counter.sv
`timescale 1ns/1ps
// Saturating up/down position counter with parallel load.
module wiper_counter #(
    parameter int POS_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [POS_W-1:0] load_val,
    input  logic             step_en,
    input  logic             up,
    output logic [POS_W-1:0] pos
);
    localparam logic [POS_W-1:0] POS_MAX = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos <= '0;
        end else if (load) begin
            pos <= load_val;
        end else if (step_en) begin
            if (up && pos != POS_MAX) begin
                pos <= pos + 1'b1;
            end else if (!up && pos != '0) begin
                pos <= pos - 1'b1;
            end
        end
    end
endmodule

// File: rtl/tap_decode.sv
`timescale 1ns/1ps
// Binary position to one-hot tap select.
module tap_decode #(
    parameter int POS_W = 7,
    localparam int TAPS = 1 << POS_W
) (
    input  logic [POS_W-1:0] pos,
    output logic [TAPS-1:0]  taps
);
    for (genvar i = 0; i < TAPS; i++) begin : g_tap
        assign taps[i] = (pos == POS_W'(i));
    end
endmodule

// File: rtl/nv_store.sv
`timescale 1ns/1ps
// Nonvolatile register model: captures on start, then counts a write time.
module nv_store #(
    parameter int             POS_W        = 7,
    parameter int             STORE_CYCLES = 5000000,
    parameter logic [POS_W-1:0] INIT_POS   = 7'd64
) (
    input  logic             clk,
    input  logic             pwr_on_n,
    input  logic             start,
    input  logic [POS_W-1:0] din,
    output logic [POS_W-1:0] dout,
    output logic             done
);
    localparam int TW = $clog2(STORE_CYCLES + 1);

    logic [TW-1:0] remain;

    always_ff @(posedge clk or negedge pwr_on_n) begin
        if (!pwr_on_n) begin
            dout   <= INIT_POS;
            remain <= '0;
        end else if (start) begin
            dout   <= din;
            remain <= TW'(STORE_CYCLES);
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign done = (remain == TW'(1));
endmodule

// File: rtl/wiper_ctrl.sv
`timescale 1ns/1ps
// Wiper position controller: select/step/direction front end, saturating
// counter, one-hot tap decode and nonvolatile store with power-up recall.
module wiper_ctrl
    import wiper_pkg::*;
#(
    parameter int             POS_W        = 7,
    parameter int             STORE_CYCLES = 5000000,
    parameter int             PWRUP_CYCLES = 750000,
    parameter logic [POS_W-1:0] INIT_POS   = 7'd64,
    localparam int            TAPS         = 1 << POS_W
) (
    input  logic             clk,
    input  logic             pwr_on_n,
    input  logic             rst_n,
    input  logic             sel_n,
    input  logic             step,
    input  logic             dir_up,
    output logic [POS_W-1:0] wiper_pos,
    output logic [TAPS-1:0]  tap_sel,
    output logic             busy,
    output logic             ready,
    output logic             standby
);
    localparam int PU_W = $clog2(PWRUP_CYCLES + 1);

    logic             sys_rst_n;
    logic [2:0]       sync_q;
    logic             sel_s, step_s, dir_s;
    logic             step_prev;
    logic             step_fall;
    wstate_e          state, nxt;
    logic             nv_start, nv_done;
    logic [POS_W-1:0] nv_q;
    logic             cnt_load, step_en;
    logic [PU_W-1:0]  pu_cnt;

    assign sys_rst_n = rst_n & pwr_on_n;

    wiper_sync #(.N(3), .RST_VAL(3'b011)) u_sync (
        .clk   (clk),
        .rst_n (sys_rst_n),
        .d     ({dir_up, step, sel_n}),
        .q     (sync_q)
    );
    assign sel_s  = sync_q[0];
    assign step_s = sync_q[1];
    assign dir_s  = sync_q[2];

    always_ff @(posedge clk or negedge sys_rst_n) begin
        if (!sys_rst_n) step_prev <= 1'b1;
        else            step_prev <= step_s;
    end
    assign step_fall = step_prev & ~step_s;

    always_ff @(posedge clk or negedge sys_rst_n) begin
        if (!sys_rst_n)                              pu_cnt <= PU_W'(PWRUP_CYCLES);
        else if (state == ST_POWERUP && pu_cnt != '0) pu_cnt <= pu_cnt - 1'b1;
    end

    // State register
    always_ff @(posedge clk or negedge sys_rst_n) begin
        if (!sys_rst_n) state <= ST_POWERUP;
        else            state <= nxt;
    end

    // Next state and control strobes
    always_comb begin
        nxt      = state;
        nv_start = 1'b0;
        step_en  = 1'b0;
        cnt_load = 1'b0;
        unique case (state)
            ST_POWERUP: begin
                cnt_load = 1'b1;
                if (pu_cnt == '0) nxt = ST_IDLE;
            end
            ST_IDLE: begin
                if (!sel_s) nxt = ST_ACTIVE;
            end
            ST_ACTIVE: begin
                if (sel_s) begin
                    if (step_s) begin
                        nxt      = ST_STORE;
                        nv_start = 1'b1;
                    end else begin
                        nxt = ST_IDLE;
                    end
                end else begin
                    step_en = step_fall;
                end
            end
            ST_STORE: begin
                if (nv_done) nxt = ST_STANDBY;
            end
            ST_STANDBY: begin
                if (!sel_s) nxt = ST_ACTIVE;
            end
            default: nxt = ST_POWERUP;
        endcase
    end

    // Outputs
    always_comb begin
        ready   = 1'b1;
        busy    = 1'b0;
        standby = 1'b0;
        unique case (state)
            ST_POWERUP: ready   = 1'b0;
            ST_IDLE:    ready   = 1'b1;
            ST_ACTIVE:  ready   = 1'b1;
            ST_STORE:   busy    = 1'b1;
            ST_STANDBY: standby = 1'b1;
            default:    ready   = 1'b0;
        endcase
    end

    wiper_counter #(.POS_W(POS_W)) u_cnt (
        .clk      (clk),
        .rst_n    (sys_rst_n),
        .load     (cnt_load),
        .load_val (nv_q),
        .step_en  (step_en),
        .up       (dir_s),
        .pos      (wiper_pos)
    );

    tap_decode #(.POS_W(POS_W)) u_dec (
        .pos  (wiper_pos),
        .taps (tap_sel)
    );

    nv_store #(
        .POS_W        (POS_W),
        .STORE_CYCLES (STORE_CYCLES),
        .INIT_POS     (INIT_POS)
    ) u_nv (
        .clk      (clk),
        .pwr_on_n (pwr_on_n),
        .start    (nv_start),
        .din      (wiper_pos),
        .dout     (nv_q),
        .done     (nv_done)
    );
endmodule

// File: rtl/wiper_ctrl_chk.sv
`timescale 1ns/1ps
module wiper_ctrl_chk
    import wiper_pkg::*;
#(
    parameter int POS_W = 7,
    localparam int TAPS = 1 << POS_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic [POS_W-1:0] wiper_pos,
    input logic [TAPS-1:0]  tap_sel,
    input logic             busy,
    input logic             ready,
    input logic             standby,
    input wstate_e          state
);
    a_r1_onehot_tap: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(tap_sel) == 1) && tap_sel[wiper_pos]);

    // R2 and R3: at most one step per clock, never wrapping
    a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && $past(ready)) |->
            ({1'b0, wiper_pos} == {1'b0, $past(wiper_pos)} ||
             {1'b0, wiper_pos} == {1'b0, $past(wiper_pos)} + 1'b1 ||
             {1'b0, wiper_pos} + 1'b1 == {1'b0, $past(wiper_pos)}));

    a_r4_hold_unselected: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && state != ST_ACTIVE) |=> $stable(wiper_pos));

    a_r7_busy_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(wiper_pos));

    a_r10_busy_standby_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && standby));

    a_r10_quiet_before_ready: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> (!busy && !standby));
endmodule

bind wiper_ctrl wiper_ctrl_chk #(.POS_W(POS_W)) u_chk (
    .clk       (clk),
    .rst_n     (sys_rst_n),
    .wiper_pos (wiper_pos),
    .tap_sel   (tap_sel),
    .busy      (busy),
    .ready     (ready),
    .standby   (standby),
    .state     (state)
);

// File: tb/wiper_ctrl_bench.sv
`timescale 1ns/1ps
module wiper_ctrl_bench;
    localparam int POS_W  = 7;
    localparam int TAPS   = 1 << POS_W;
    localparam int STORE  = 50;
    localparam int PWRUP  = 20;
    localparam int INIT   = 64;

    logic             clk = 1'b0;
    logic             pwr_on_n = 1'b0;
    logic             rst_n = 1'b0;
    logic             sel_n = 1'b1;
    logic             step = 1'b1;
    logic             dir_up = 1'b1;
    logic [POS_W-1:0] wiper_pos;
    logic [TAPS-1:0]  tap_sel;
    logic             busy, ready, standby;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    wiper_ctrl #(
        .POS_W(POS_W), .STORE_CYCLES(STORE), .PWRUP_CYCLES(PWRUP), .INIT_POS(7'(INIT))
    ) u_wiper_ctrl (
        .clk(clk), .pwr_on_n(pwr_on_n), .rst_n(rst_n), .sel_n(sel_n),
        .step(step), .dir_up(dir_up), .wiper_pos(wiper_pos), .tap_sel(tap_sel),
        .busy(busy), .ready(ready), .standby(standby)
    );

    // {dir_up, number of steps, expected position}
    localparam logic [15:0] VEC [8] = '{
        {1'b1, 8'd10,  7'd74},
        {1'b0, 8'd5,   7'd69},
        {1'b1, 8'd70,  7'd127},
        {1'b1, 8'd3,   7'd127},
        {1'b0, 8'd130, 7'd0},
        {1'b0, 8'd2,   7'd0},
        {1'b1, 8'd1,   7'd1},
        {1'b1, 8'd126, 7'd127}
    };

    task automatic check(input string req, input logic [TAPS-1:0] act, input logic [TAPS-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_step(input logic up);
        dir_up = up;
        cyc(2);
        step = 1'b0;
        cyc(4);
        step = 1'b1;
        cyc(4);
    endtask

    task automatic do_steps(input logic up, input int n);
        for (int i = 0; i < n; i++) pulse_step(up);
        cyc(4);
    endtask

    task automatic power_up(input logic cold);
        cyc(1);
        rst_n = 1'b0;
        if (cold) pwr_on_n = 1'b0;
        cyc(3);
        rst_n = 1'b1;
        pwr_on_n = 1'b1;
    endtask

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        // Cold power-on
        power_up(1'b1);
        cyc(5);
        check("R8 ready low during delay", TAPS'(ready), TAPS'(0));
        check("R10 quiet before ready", TAPS'({busy, standby}), TAPS'(0));
        cyc(PWRUP + 4);
        check("R8 ready high", TAPS'(ready), TAPS'(1));
        check("R9 init position", TAPS'(wiper_pos), TAPS'(INIT));
        check("R1 tap at init", tap_sel, TAPS'(1) << INIT);
        check("R5 no busy/standby at reset", TAPS'({busy, standby}), TAPS'(0));

        // Table walk (R2, R3, R1)
        sel_n = 1'b0;
        cyc(6);
        for (int v = 0; v < 8; v++) begin
            do_steps(VEC[v][15], int'(VEC[v][14:7]));
            check("R2/R3 table position", TAPS'(wiper_pos), TAPS'(VEC[v][6:0]));
            check("R1 table tap", tap_sel, TAPS'(1) << VEC[v][6:0]);
        end

        // R6: release with step low -> no store; R4: steps ignored deselected
        step = 1'b0;
        cyc(4);
        sel_n = 1'b1;
        cyc(8);
        check("R6 no busy on release with step low", TAPS'(busy), TAPS'(0));
        step = 1'b1;
        cyc(4);
        do_steps(1'b0, 3);
        check("R4 ignored while deselected", TAPS'(wiper_pos), TAPS'(127));

        // R5: store 100
        sel_n = 1'b0;
        cyc(6);
        do_steps(1'b0, 27);
        check("R2 down to 100", TAPS'(wiper_pos), TAPS'(100));
        sel_n = 1'b1;
        cyc(6);
        check("R5 busy after release with step high", TAPS'(busy), TAPS'(1));
        // R7: activity during busy ignored
        sel_n = 1'b0;
        cyc(2);
        pulse_step(1'b1);
        pulse_step(1'b1);
        check("R7 frozen during busy", TAPS'(wiper_pos), TAPS'(100));
        check("R7 still busy", TAPS'(busy), TAPS'(1));
        sel_n = 1'b1;
        cyc(STORE + 5);
        check("R5 busy ended", TAPS'(busy), TAPS'(0));
        check("R5 standby after store", TAPS'(standby), TAPS'(1));
        check("R7 position after store", TAPS'(wiper_pos), TAPS'(100));
        sel_n = 1'b0;
        cyc(6);
        check("R5 standby cleared on select", TAPS'(standby), TAPS'(0));

        // R6: move to 90, release with step low, then warm reset recalls 100
        do_steps(1'b0, 10);
        check("R2 down to 90", TAPS'(wiper_pos), TAPS'(90));
        step = 1'b0;
        cyc(4);
        sel_n = 1'b1;
        cyc(6);
        step = 1'b1;
        cyc(4);
        power_up(1'b0);
        sel_n = 1'b0;
        cyc(2);
        pulse_step(1'b1);
        check("R8 ready low after warm reset", TAPS'(ready), TAPS'(0));
        cyc(PWRUP + 4);
        check("R6/R8 recalled stored value", TAPS'(wiper_pos), TAPS'(100));
        check("R1 tap after recall", tap_sel, TAPS'(1) << 100);

        // R9: cold power-on restores INIT
        power_up(1'b1);
        cyc(PWRUP + 8);
        check("R9 cold init again", TAPS'(wiper_pos), TAPS'(INIT));

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule